// File: doc/BRIEF.md
# Slow Three-Wire Sensor Reader

This block is a bus master that fetches readings from a hardware-monitor device over a three-wire serial link. The link has an active-low chip select, a clock driven by this block, and one data line driven by the device. A single read request lowers chip select and waits a long setup interval. The block then clocks in one 32-bit word at a very low bit rate and releases chip select. One word always carries both the fan speed and the temperature, so one transaction refreshes both values.

The word's top byte is a marker that tells whether the device answered properly. A good word updates the cached fan and temperature fields. A bad word raises an error flag and leaves the cache as it was. After a good read, a hold-off window starts. Requests that arrive inside this window are answered at once from the cache, with no bus activity. Every interval (setup, clock phase, hold-off) is a parameter counted in system-clock cycles. The setup and phase intervals are clamped from below by minimum parameters, because the device goes silent, or bits get sampled twice, when these intervals are too short.

Top module: `sensor_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, done_o, valid_o and err_o are 0, and fan_o and temp_o are 0.
- R2: The first request after reset always starts a bus transaction. In every transaction, cs_n_o stays low for exactly max(SETUP_CYC, SETUP_MIN_CYC) cycles before the first rising edge of sck_o.
- R3: The high phase and the low phase of sck_o between bits each last exactly max(HALF_CYC, HALF_MIN_CYC) cycles. There are exactly 32 rising edges per chip-select assertion, and sck_o is never 1 while cs_n_o is 1.
- R4: sdi_i is sampled at each rising edge of sck_o, most significant bit first. In the word, bits 31..24 hold the marker, bits 23..16 hold the fan speed (units of 100 RPM), and bits 15..0 hold the temperature (tenths of a degree).
- R5: When the marker equals 0x55, the transaction ends with fan_o and temp_o loaded from the word, valid_o at 1, err_o at 0, and a done_o pulse exactly one cycle wide.
- R6: When the marker differs from 0x55, err_o goes to 1 with the done_o pulse, and fan_o, temp_o and valid_o keep their old values. The hold-off window is cancelled, so the next request reads the bus again.
- R7: A request sampled within HOLD_CYC cycles after a good transaction completes gives done_o on the next cycle. It leaves cs_n_o high and fan_o and temp_o unchanged.
- R8: A request that arrives after the hold-off window has expired starts a new bus transaction and returns the new values.
- R9: After the 32nd bit, cs_n_o returns to 1 together with sck_o falling. It stays high for exactly max(HALF_CYC, HALF_MIN_CYC) cycles before done_o.
- R10: A request that arrives while a transaction is in progress is ignored. It starts no second transaction and produces no extra done_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request, sampled while idle |
| done_o | output | 1 | One-cycle pulse when a request has been answered |
| valid_o | output | 1 | Cache holds at least one good reading |
| err_o | output | 1 | Last bus transaction had a bad marker |
| fan_o | output | 8 | Cached fan speed, 100 RPM units |
| temp_o | output | 16 | Cached temperature, tenths of a degree |
| cs_n_o | output | 1 | Chip select to the device, active low |
| sck_o | output | 1 | Serial clock to the device, idles low |
| sdi_i | input | 1 | Serial data from the device |

## Verification
The embedded assertions check the following on every cycle: the serial clock never runs with chip select released, done is always a single-cycle pulse, a bad marker never disturbs the cached fields, the valid flag never drops, a cache hit never touches the bus, and the bit counter never passes 32. Other properties can only be shown by the bench scenarios, because they depend on exact counts or on data: the exact lengths of the setup, phase and release intervals, including the lower clamp; bit order and field placement; the hold-off window and its expiry; cancelling the window after an error; and ignoring requests while busy.

// File: rtl/sr_pkg.sv
// Package for the sensor reader: word layout, marker value and controller states.
// Assumes a 32-bit frame with the marker in the top byte.
package sr_pkg;
    localparam int WORD_W = 32;
    localparam int FAN_W  = 8;
    localparam int TEMP_W = 16;
    localparam int MARK_W = WORD_W - FAN_W - TEMP_W;
    localparam logic [MARK_W-1:0] MARK_VAL = 8'h55;

    typedef struct packed {
        logic [MARK_W-1:0] marker;
        logic [FAN_W-1:0]  fan;
        logic [TEMP_W-1:0] temp;
    } sr_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } sr_state_t;
endpackage

// File: rtl/sr_countdown.sv
// Loadable down-counter that stops at zero.
// Used for the phase timer and for the hold-off timer. The load input wins over counting.
module sr_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down until zero is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sr_shift.sv
// Serial capture register: shifts the data line in MSB first, one bit per sample strobe.
// Assumes that sample is never raised once WIDTH bits have been taken.
module sr_shift #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             sdi,
    output logic [WIDTH-1:0] word,
    output logic             full
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] count;

    // Shift the new bit in at the LSB, so that the first bit ends up at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (clear) begin
            word  <= '0;
            count <= '0;
        end else if (sample) begin
            word  <= {word[WIDTH-2:0], sdi};
            count <= count + 1'b1;
        end
    end

    assign full = (count == CW'(WIDTH));

    // R3: at most 32 bits per transaction
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(WIDTH));
    // R3: no sample once the frame is complete
    a_r3_no_extra_bit: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clear |-> !sample);
endmodule

// File: rtl/sr_decode.sv
// Frame decoder: checks the marker byte and splits out the fan and temperature fields.
// Purely combinational. The captured word must be stable while it is used.
module sr_decode
    import sr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              ok,
    output logic [FAN_W-1:0]  fan,
    output logic [TEMP_W-1:0] temp
);
    sr_word_t f;

    // Map the raw bits onto the frame fields and test the marker.
    always_comb begin
        f    = sr_word_t'(word);
        ok   = (f.marker == MARK_VAL);
        fan  = f.fan;
        temp = f.temp;
    end
endmodule

// File: rtl/sensor_reader.sv
// Top of the slow three-wire sensor reader.
// On req_i it either answers from the cache (hold-off window active) or runs a
// full transaction: chip select low, setup wait, 32 clock periods with sampling
// on each rising edge, then chip select high for one phase, then done_o.
// Assumes that req_i is a level sampled in idle. All intervals are in clk cycles.
module sensor_reader
    import sr_pkg::*;
#(
    parameter int SETUP_CYC     = 10_000_000,
    parameter int SETUP_MIN_CYC = 1_000_000,
    parameter int HALF_CYC      = 10_000,
    parameter int HALF_MIN_CYC  = 1_500,
    parameter int HOLD_CYC      = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              done_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [FAN_W-1:0]  fan_o,
    output logic [TEMP_W-1:0] temp_o,
    output logic              cs_n_o,
    output logic              sck_o,
    input  logic              sdi_i
);
    localparam int SETUP_EFF = (SETUP_CYC < SETUP_MIN_CYC) ? SETUP_MIN_CYC : SETUP_CYC;
    localparam int HALF_EFF  = (HALF_CYC < HALF_MIN_CYC) ? HALF_MIN_CYC : HALF_CYC;
    localparam int PH_MAX    = (SETUP_EFF > HALF_EFF) ? SETUP_EFF : HALF_EFF;
    localparam int PW        = $clog2(PH_MAX + 1);
    localparam int HW        = $clog2(HOLD_CYC + 1);
    localparam logic [PW-1:0] SETUP_LD = PW'(SETUP_EFF - 1);
    localparam logic [PW-1:0] HALF_LD  = PW'(HALF_EFF - 1);
    localparam logic [HW-1:0] HOLD_LD  = HW'(HOLD_CYC);

    sr_state_t         state;
    logic              ph_load, ph_zero;
    logic [PW-1:0]     ph_val;
    logic              hold_load, hold_zero;
    logic [HW-1:0]     hold_val;
    logic              hit, start, sample, sh_full;
    logic [WORD_W-1:0] sh_word;
    logic              dec_ok;
    logic [FAN_W-1:0]  dec_fan;
    logic [TEMP_W-1:0] dec_temp;

    // Cache hit when the cache is valid and the hold-off window is still open.
    assign hit   = valid_o && !hold_zero;
    assign start = (state == ST_IDLE) && req_i && !hit;
    // Sample the data line at the very edge that raises the serial clock.
    assign sample = ph_zero && ((state == ST_SETUP) || (state == ST_LOW));

    // Phase timer reload: the setup length on start, otherwise one half period.
    always_comb begin
        ph_load = start || (ph_zero && (state == ST_SETUP || state == ST_HIGH || state == ST_LOW));
        ph_val  = start ? SETUP_LD : HALF_LD;
    end

    // Hold-off reload at the end of each transaction: open on success, close on error.
    always_comb begin
        hold_load = (state == ST_GAP) && ph_zero;
        hold_val  = dec_ok ? HOLD_LD : '0;
    end

    sr_countdown #(.W(PW)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    sr_countdown #(.W(HW)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_val),
        .zero     (hold_zero)
    );

    sr_shift #(.WIDTH(WORD_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .sample (sample),
        .sdi    (sdi_i),
        .word   (sh_word),
        .full   (sh_full)
    );

    sr_decode i_decode (
        .word (sh_word),
        .ok   (dec_ok),
        .fan  (dec_fan),
        .temp (dec_temp)
    );

    // Transaction sequencer: drives the pins, the done pulse and the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cs_n_o  <= 1'b1;
            sck_o   <= 1'b0;
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            fan_o   <= '0;
            temp_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_i && hit) begin
                        done_o <= 1'b1;
                    end else if (start) begin
                        cs_n_o <= 1'b0;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (ph_zero) begin
                        sck_o <= 1'b1;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (ph_zero) begin
                        sck_o <= 1'b0;
                        if (sh_full) begin
                            cs_n_o <= 1'b1;
                            state  <= ST_GAP;
                        end else begin
                            state  <= ST_LOW;
                        end
                    end
                end
                ST_GAP: begin
                    if (ph_zero) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                        if (dec_ok) begin
                            fan_o   <= dec_fan;
                            temp_o  <= dec_temp;
                            valid_o <= 1'b1;
                            err_o   <= 1'b0;
                        end else begin
                            err_o   <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the serial clock runs only while chip select is asserted
    a_r3_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);
    // R2: the first rising clock edge comes after chip select was already low
    a_r2_rise_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $past(!cs_n_o));
    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: the cache, once valid, stays valid
    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(valid_o));
    // R6: an error result leaves the cached fields untouched
    a_r6_err_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> $stable(fan_o) && $stable(temp_o));
    // R7: a cache hit answers next cycle without touching the bus
    a_r7_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && req_i && hit |=> done_o && cs_n_o && $stable(fan_o));
    // R10: no done pulse can come out while the bits are still being clocked
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP || state == ST_HIGH || state == ST_LOW) |=> !done_o);
    // R9: chip select rises only together with a falling serial clock
    a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $fell(sck_o));
endmodule

// File: tb/test_sensor_reader.sv
// Directed bench for sensor_reader with a behavioural device model and a pin monitor.
`timescale 1ns/1ps
module test_sensor_reader;
    localparam int SETUP_CYC = 20, SETUP_MIN = 10;
    localparam int HALF_CYC  = 3,  HALF_MIN  = 4;   // phase clamp raises this to 4
    localparam int HOLD_CYC  = 400;
    localparam int SETUP_EXP = 20, HALF_EXP = 4;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sdi = 1'b0;
    logic done_o, valid_o, err_o, cs_n_o, sck_o;
    logic [7:0]  fan_o;
    logic [15:0] temp_o;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [31:0] dev_word = 32'h0;

    // monitor state
    int txn_cnt = 0, done_cnt = 0, sck_bad = 0;
    int rises = 0, setup_cnt = 0, run = 0, gap_cnt = 0, bit_idx = 31;
    int meas_setup = 0, meas_gap = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    bit in_gap = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;

    always #5 clk = ~clk;

    sensor_reader #(
        .SETUP_CYC(SETUP_CYC), .SETUP_MIN_CYC(SETUP_MIN),
        .HALF_CYC(HALF_CYC), .HALF_MIN_CYC(HALF_MIN), .HOLD_CYC(HOLD_CYC)
    ) i_sensor_reader (
        .clk(clk), .rst_n(rst_n), .req_i(req), .done_o(done_o), .valid_o(valid_o),
        .err_o(err_o), .fan_o(fan_o), .temp_o(temp_o), .cs_n_o(cs_n_o),
        .sck_o(sck_o), .sdi_i(sdi)
    );

    // Device model and pin monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sck = 1'b0;
        end else begin
            if (done_o) done_cnt++;
            if (sck_o && cs_n_o) sck_bad++;
            if (prev_cs && !cs_n_o) begin
                txn_cnt++; rises = 0; setup_cnt = 0; run = 0; gap_cnt = 0;
                hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
                bit_idx = 31; sdi = dev_word[31];
            end
            if (!cs_n_o) begin
                if (!prev_sck && sck_o) begin
                    rises++;
                    if (rises == 1) meas_setup = setup_cnt;
                    else begin
                        if (run < lo_min) lo_min = run;
                        if (run > lo_max) lo_max = run;
                    end
                    run = 1;
                end else if (prev_sck && !sck_o) begin
                    if (run < hi_min) hi_min = run;
                    if (run > hi_max) hi_max = run;
                    run = 1;
                    bit_idx--;
                    sdi = dev_word[bit_idx];
                end else begin
                    run++;
                    if (rises == 0) setup_cnt++;
                end
            end else if (!prev_cs) begin
                if (run < hi_min) hi_min = run;
                if (run > hi_max) hi_max = run;
                gap_cnt = 1; in_gap = 1;
            end else if (in_gap) begin
                if (done_o) begin meas_gap = gap_cnt; in_gap = 0; end
                else gap_cnt++;
            end
            prev_cs = cs_n_o; prev_sck = sck_o;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (done_o) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_hold();
        repeat (HOLD_CYC + 10) @(negedge clk);
    endtask

    // R1: reset values on every output
    task automatic t_reset();
        check(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
        check(sck_o == 1'b0, "R1 sck", int'(sck_o), 0);
        check({done_o, valid_o, err_o} == 3'b000, "R1 flags", int'({done_o, valid_o, err_o}), 0);
        check(fan_o == 8'd0 && temp_o == 16'd0, "R1 fields", int'({fan_o, temp_o}), 0);
    endtask

    // R2 R3 R4 R5 R9: first read after reset with full pin timing
    task automatic t_first_read();
        int t0 = txn_cnt, d0 = done_cnt;
        dev_word = 32'h552A01F4;
        pulse_req();
        wait_done();
        @(negedge clk);
        check(txn_cnt == t0 + 1, "R2 first req reads bus", txn_cnt - t0, 1);
        check(meas_setup == SETUP_EXP, "R2 setup length", meas_setup, SETUP_EXP);
        check(rises == 32, "R3 rising edges", rises, 32);
        check(hi_min == HALF_EXP && hi_max == HALF_EXP, "R3 high phase", hi_max, HALF_EXP);
        check(lo_min == HALF_EXP && lo_max == HALF_EXP, "R3 low phase", lo_max, HALF_EXP);
        check(sck_bad == 0, "R3 sck with cs high", sck_bad, 0);
        check(meas_gap == HALF_EXP, "R9 release gap", meas_gap, HALF_EXP);
        check(fan_o == 8'h2A, "R4 fan field", int'(fan_o), 'h2A);
        check(temp_o == 16'h01F4, "R4 temp field", int'(temp_o), 'h01F4);
        check(valid_o && !err_o, "R5 flags", int'({valid_o, err_o}), 2);
        check(done_cnt == d0 + 1, "R5 single done", done_cnt - d0, 1);
    endtask

    // R7: request inside hold-off served from cache
    task automatic t_cache_hit();
        int t0 = txn_cnt;
        dev_word = 32'h55FF8001;
        pulse_req();
        check(done_o == 1'b1, "R7 immediate done", int'(done_o), 1);
        check(cs_n_o == 1'b1, "R7 cs stays high", int'(cs_n_o), 1);
        repeat (3) @(negedge clk);
        check(txn_cnt == t0, "R7 no transaction", txn_cnt - t0, 0);
        check(fan_o == 8'h2A && temp_o == 16'h01F4, "R7 cached values", int'(temp_o), 'h01F4);
    endtask

    // R8 R10 R4: expired window reads again; a second request while busy is dropped
    task automatic t_expire_busy();
        int t0, d0;
        wait_hold();
        t0 = txn_cnt; d0 = done_cnt;
        pulse_req();
        repeat (60) @(negedge clk);
        pulse_req();
        wait_done();
        repeat (HOLD_CYC / 2) @(negedge clk);
        check(txn_cnt == t0 + 1, "R10 one transaction", txn_cnt - t0, 1);
        check(done_cnt == d0 + 1, "R10 one done", done_cnt - d0, 1);
        check(fan_o == 8'hFF, "R8 new fan", int'(fan_o), 'hFF);
        check(temp_o == 16'h8001, "R4 msb-first temp", int'(temp_o), 'h8001);
    endtask

    // R6: bad marker keeps cache, raises err, and reopens the bus
    task automatic t_bad_marker();
        int t0;
        wait_hold();
        dev_word = 32'h54112222;
        pulse_req();
        wait_done();
        @(negedge clk);
        check(err_o == 1'b1, "R6 err set", int'(err_o), 1);
        check(fan_o == 8'hFF && temp_o == 16'h8001, "R6 cache kept", int'(temp_o), 'h8001);
        check(valid_o == 1'b1, "R6 valid kept", int'(valid_o), 1);
        t0 = txn_cnt;
        dev_word = 32'h550700FA;
        pulse_req();
        wait_done();
        @(negedge clk);
        check(txn_cnt == t0 + 1, "R6 window cancelled", txn_cnt - t0, 1);
        check(fan_o == 8'h07 && temp_o == 16'h00FA, "R5 good after error", int'(temp_o), 'h00FA);
        check(err_o == 1'b0, "R5 err cleared", int'(err_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_read();
        t_cache_hit();
        t_expire_busy();
        t_bad_marker();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule